// File: doc/BRIEF.md
# Bus Remote Wake Detector

This block decides, while a bus transceiver is asleep, whether activity on the single-wire bus is a genuine remote wake-up request. Three digitized comparator flags describe the bus level: below the pre-wake low threshold, at dominant level, and above the pre-wake high threshold. When the bus drops below the pre-wake low threshold, the block turns on a monitoring receiver. While that receiver is on, it waits for a dominant phase that lasts at least the wake filter time and then ends on a rising edge. When that happens it sends a one-cycle wake request to the mode controller.

The receiver may only stay on for a bounded monitoring window. If the window closes while the bus floats between the thresholds, the block goes back to a low-power lockout. It leaves the lockout only after the bus has been above the pre-wake high threshold for a programmable number of cycles. If the window closes while the bus is still dominant, the block treats the bus as shorted. It issues nothing during the short, and wakes directly on the edge that ends it. The block works only while the mode controller reports sleep.

Top module: `bus_wake_qualifier`

## Requirements
- R1: While `rst` is high, `monitor_on` and `wake_req` are 0 from the first clock edge, and they stay 0 until reset is released.
- R2: Each bus flag passes through `SYNC_STAGES` flip-flops. A flag change applied before clock edge k shows at the outputs after edge k+`SYNC_STAGES` (the third edge with the default of 2).
- R3: In sleep with the block idle, `monitor_on` stays 0 while the bus is recessive. `monitor_on` rises once `bus_below_lo`=1 reaches the detector.
- R4: While monitoring, a dominant phase (`bus_dominant`=1) that lasts at least `FILTER_CYCLES` synchronized cycles and then ends produces exactly one `wake_req` pulse. A shorter dominant phase produces none, and monitoring continues.
- R5: If no qualified wake occurs, `monitor_on` stays high for exactly `WINDOW_CYCLES` cycles. It then drops without a wake when the bus is not dominant at expiry.
- R6: If the bus is still dominant when the window expires, `monitor_on` drops, and no `wake_req` is issued for as long as the bus stays dominant.
- R7: After such a timed-out dominant phase, the first cycle in which the bus is not dominant produces one `wake_req`, without any filter time.
- R8: After a window expiry or a wake, a new monitoring phase needs `bus_above_hi`=1 for `REARM_CYCLES` consecutive cycles first. Shorter runs are ignored, and while locked out a drop below pre-wake low leaves `monitor_on` at 0.
- R9: With `sleep_mode`=0 the block is idle. `monitor_on` falls one edge after `sleep_mode` falls, and no `wake_req` is produced, whatever the bus does.
- R10: `wake_req` is high for a single cycle and is never high in the same cycle as `monitor_on`.
- R11: If the bus rises back above pre-wake low (`bus_below_lo`=0) while monitoring, with no qualified dominant phase pending, the block returns to idle. No high-level re-arm is required before the next monitoring phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_mode | input | 1 | 1 while the mode controller is in sleep; enables detection |
| bus_below_lo | input | 1 | Comparator flag: bus below pre-wake low threshold (asynchronous) |
| bus_dominant | input | 1 | Comparator flag: bus at dominant level (asynchronous) |
| bus_above_hi | input | 1 | Comparator flag: bus above pre-wake high threshold (asynchronous) |
| monitor_on | output | 1 | Monitoring receiver enable; high during the monitoring window |
| wake_req | output | 1 | One-cycle remote wake request to the mode controller |

## Verification
A detector stuck in the wrong state shows up first on `monitor_on`. If it is stuck in lockout, `monitor_on` fails to rise three edges after the bus dips. If it skips the lockout, `monitor_on` rises when it should stay low. A wrong filter count shows up on `wake_req`: a pulse appears, or fails to appear, three edges after the dominant phase ends, so the seven- versus eight-cycle boundary is decided within a single vector. A wrong window length changes how many cycles `monitor_on` stays high, and the bench counts those cycles exactly.

// File: rtl/bwq_pkg.sv
package bwq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WATCH = 2'd1,
        ST_SHORT = 2'd2,
        ST_REARM = 2'd3
    } det_state_e;

    typedef struct packed {
        logic below_lo;
        logic dominant;
        logic above_hi;
    } bus_lvl_t;

    localparam int unsigned LVL_BITS = 3;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 1) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/bwq_sync.sv
module bwq_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) begin
                pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/bwq_timer.sv
module bwq_timer #(
    parameter int unsigned LIMIT = 8,
    parameter int unsigned W     = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] TOP = W'(LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && (count != TOP)) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/bwq_fsm.sv
module bwq_fsm
    import bwq_pkg::*;
#(
    parameter int unsigned FILTER_CYCLES = 8,
    parameter int unsigned WINDOW_CYCLES = 40,
    parameter int unsigned REARM_CYCLES  = 4,
    parameter int unsigned DW = 4,
    parameter int unsigned WW = 6,
    parameter int unsigned RW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sleep_mode,
    input  bus_lvl_t      lvl,
    input  logic [DW-1:0] dom_cnt,
    input  logic [WW-1:0] win_cnt,
    input  logic [RW-1:0] hi_cnt,
    output logic          dom_inc,
    output logic          dom_clr,
    output logic          win_inc,
    output logic          win_clr,
    output logic          hi_inc,
    output logic          hi_clr,
    output det_state_e    state,
    output logic          wake_req
);
    localparam logic [DW-1:0] FILT_MIN = DW'(FILTER_CYCLES);
    localparam logic [WW-1:0] WIN_LAST = WW'(WINDOW_CYCLES - 1);
    localparam logic [RW-1:0] HI_LAST  = RW'(REARM_CYCLES - 1);

    det_state_e state_nxt;
    logic       wake_nxt;

    // counter steering follows the present state
    always_comb begin
        dom_inc = (state == ST_WATCH) && lvl.dominant;
        dom_clr = !dom_inc;
        win_inc = (state == ST_WATCH);
        win_clr = !win_inc;
        hi_inc  = (state == ST_REARM) && lvl.above_hi;
        hi_clr  = !hi_inc;
    end

    always_comb begin
        state_nxt = state;
        wake_nxt  = 1'b0;
        if (!sleep_mode) begin
            state_nxt = ST_IDLE;                       // R9
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (lvl.below_lo) state_nxt = ST_WATCH;   // R3
                end
                ST_WATCH: begin
                    if (!lvl.dominant && (dom_cnt >= FILT_MIN)) begin
                        wake_nxt  = 1'b1;              // R4
                        state_nxt = ST_REARM;
                    end else if (win_cnt >= WIN_LAST) begin
                        state_nxt = lvl.dominant ? ST_SHORT : ST_REARM; // R5 R6
                    end else if (!lvl.below_lo) begin
                        state_nxt = ST_IDLE;           // R11
                    end
                end
                ST_SHORT: begin
                    if (!lvl.dominant) begin
                        wake_nxt  = 1'b1;              // R7
                        state_nxt = ST_REARM;
                    end
                end
                ST_REARM: begin
                    if (lvl.above_hi && (hi_cnt >= HI_LAST)) state_nxt = ST_IDLE; // R8
                end
                default: state_nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            wake_req <= 1'b0;
        end else begin
            state    <= state_nxt;
            wake_req <= wake_nxt;
        end
    end
endmodule

// File: rtl/bus_wake_qualifier.sv
module bus_wake_qualifier
    import bwq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned FILTER_CYCLES = 9000,
    parameter int unsigned WINDOW_CYCLES = 1000000,
    parameter int unsigned REARM_CYCLES  = 300
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep_mode,
    input  logic bus_below_lo,
    input  logic bus_dominant,
    input  logic bus_above_hi,
    output logic monitor_on,
    output logic wake_req
);
    localparam int unsigned DW = cnt_width(FILTER_CYCLES);
    localparam int unsigned WW = cnt_width(WINDOW_CYCLES);
    localparam int unsigned RW = cnt_width(REARM_CYCLES);

    bus_lvl_t raw_lvl, lvl;
    det_state_e state;
    logic [DW-1:0] dom_cnt;
    logic [WW-1:0] win_cnt;
    logic [RW-1:0] hi_cnt;
    logic dom_inc, dom_clr, win_inc, win_clr, hi_inc, hi_clr;

    assign raw_lvl = '{below_lo: bus_below_lo, dominant: bus_dominant, above_hi: bus_above_hi};

    // R2: flags cross into the clock domain
    bwq_sync #(.WIDTH(LVL_BITS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(raw_lvl), .q(lvl)
    );

    bwq_timer #(.LIMIT(FILTER_CYCLES), .W(DW)) u_dom_tmr (
        .clk(clk), .rst(rst), .clr(dom_clr), .inc(dom_inc), .count(dom_cnt)
    );

    bwq_timer #(.LIMIT(WINDOW_CYCLES), .W(WW)) u_win_tmr (
        .clk(clk), .rst(rst), .clr(win_clr), .inc(win_inc), .count(win_cnt)
    );

    bwq_timer #(.LIMIT(REARM_CYCLES), .W(RW)) u_hi_tmr (
        .clk(clk), .rst(rst), .clr(hi_clr), .inc(hi_inc), .count(hi_cnt)
    );

    bwq_fsm #(
        .FILTER_CYCLES(FILTER_CYCLES), .WINDOW_CYCLES(WINDOW_CYCLES),
        .REARM_CYCLES(REARM_CYCLES), .DW(DW), .WW(WW), .RW(RW)
    ) u_fsm (
        .clk(clk), .rst(rst), .sleep_mode(sleep_mode), .lvl(lvl),
        .dom_cnt(dom_cnt), .win_cnt(win_cnt), .hi_cnt(hi_cnt),
        .dom_inc(dom_inc), .dom_clr(dom_clr), .win_inc(win_inc),
        .win_clr(win_clr), .hi_inc(hi_inc), .hi_clr(hi_clr),
        .state(state), .wake_req(wake_req)
    );

    assign monitor_on = (state == ST_WATCH);
endmodule

// File: rtl/bwq_checker.sv
module bwq_checker #(
    parameter int unsigned WINDOW_CYCLES = 40
) (
    input logic clk,
    input logic rst,
    input logic sleep_mode,
    input logic monitor_on,
    input logic wake_req
);
    int unsigned mon_run;

    always_ff @(posedge clk) begin
        if (rst || !monitor_on) begin
            mon_run <= 0;
        end else if (mon_run < WINDOW_CYCLES + 1) begin
            mon_run <= mon_run + 1;
        end
    end

    assert_wake_only_asleep_R9: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> $past(sleep_mode));

    assert_monitor_only_asleep_R9: assert property (@(posedge clk) disable iff (rst)
        monitor_on |-> $past(sleep_mode));

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        wake_req |=> !wake_req);

    assert_no_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wake_req, monitor_on}));

    assert_window_bound_R5: assert property (@(posedge clk) disable iff (rst)
        mon_run <= WINDOW_CYCLES);
endmodule

bind bus_wake_qualifier bwq_checker #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .sleep_mode(sleep_mode),
    .monitor_on(monitor_on), .wake_req(wake_req)
);

// File: tb/sim_bus_wake_qualifier.sv
module sim_bus_wake_qualifier;
    localparam int unsigned FILT = 8;
    localparam int unsigned WIN  = 40;
    localparam int unsigned RARM = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_mode = 1'b1;
    logic lo = 1'b0, dm = 1'b0, hi = 1'b1;
    logic monitor_on, wake_req;

    int checks = 0;
    int errors = 0;
    int overlaps = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bus_wake_qualifier #(
        .SYNC_STAGES(2), .FILTER_CYCLES(FILT),
        .WINDOW_CYCLES(WIN), .REARM_CYCLES(RARM)
    ) u0 (
        .clk(clk), .rst(rst), .sleep_mode(sleep_mode),
        .bus_below_lo(lo), .bus_dominant(dm), .bus_above_hi(hi),
        .monitor_on(monitor_on), .wake_req(wake_req)
    );

    typedef struct packed {
        logic       sl;
        logic       lo;
        logic       dm;
        logic       hi;
        logic [7:0] hold;
        logic       mon;
        logic [1:0] wk;
        logic [7:0] mcnt;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    // sleep, below_lo, dominant, above_hi, hold, end monitor, wakes, monitor cycles, requirement
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,1'b1,8'd5, 1'b0,2'd0,8'd0, 4'd3},   // R3 recessive, no monitor
        '{1'b1,1'b1,1'b0,1'b0,8'd4, 1'b1,2'd0,8'd2, 4'd2},   // R2 monitor after third edge
        '{1'b1,1'b1,1'b1,1'b0,8'd7, 1'b1,2'd0,8'd7, 4'd4},   // R4 short dominant
        '{1'b1,1'b1,1'b0,1'b0,8'd4, 1'b1,2'd0,8'd4, 4'd4},   // R4 no wake, still watching
        '{1'b1,1'b1,1'b1,1'b0,8'd8, 1'b1,2'd0,8'd8, 4'd4},   // R4 qualified dominant
        '{1'b1,1'b1,1'b0,1'b0,8'd4, 1'b0,2'd1,8'd2, 4'd4},   // R4 wake on release
        '{1'b1,1'b1,1'b0,1'b0,8'd5, 1'b0,2'd0,8'd0, 4'd8},   // R8 locked out
        '{1'b1,1'b0,1'b0,1'b1,8'd3, 1'b0,2'd0,8'd0, 4'd8},   // R8 high too short
        '{1'b1,1'b1,1'b0,1'b0,8'd5, 1'b0,2'd0,8'd0, 4'd8},   // R8 still locked
        '{1'b1,1'b0,1'b0,1'b1,8'd4, 1'b0,2'd0,8'd0, 4'd8},   // R8 re-arm
        '{1'b1,1'b1,1'b0,1'b0,8'd45,1'b0,2'd0,8'd40,4'd5},   // R5 floating window
        '{1'b1,1'b1,1'b0,1'b0,8'd5, 1'b0,2'd0,8'd0, 4'd5},   // R5 stays asleep
        '{1'b1,1'b0,1'b0,1'b1,8'd4, 1'b0,2'd0,8'd0, 4'd8},   // R8 re-arm
        '{1'b1,1'b1,1'b0,1'b0,8'd4, 1'b1,2'd0,8'd2, 4'd3},   // R3 monitor
        '{1'b1,1'b1,1'b1,1'b0,8'd50,1'b0,2'd0,8'd38,4'd6},   // R6 shorted bus
        '{1'b1,1'b1,1'b0,1'b0,8'd5, 1'b0,2'd1,8'd0, 4'd7},   // R7 direct wake
        '{1'b1,1'b0,1'b0,1'b1,8'd4, 1'b0,2'd0,8'd0, 4'd8},   // R8 re-arm
        '{1'b1,1'b1,1'b0,1'b0,8'd4, 1'b1,2'd0,8'd2, 4'd3},   // R3 monitor
        '{1'b1,1'b0,1'b0,1'b0,8'd4, 1'b0,2'd0,8'd2, 4'd11},  // R11 bus recovers
        '{1'b1,1'b1,1'b0,1'b0,8'd4, 1'b1,2'd0,8'd2, 4'd11},  // R11 immediate re-arm
        '{1'b0,1'b1,1'b0,1'b0,8'd4, 1'b0,2'd0,8'd0, 4'd9},   // R9 leave sleep
        '{1'b0,1'b1,1'b1,1'b0,8'd10,1'b0,2'd0,8'd0, 4'd9},   // R9 dominant ignored
        '{1'b0,1'b1,1'b0,1'b0,8'd4, 1'b0,2'd0,8'd0, 4'd9},   // R9 release ignored
        '{1'b1,1'b1,1'b0,1'b0,8'd4, 1'b1,2'd0,8'd4, 4'd9}    // R9 sleep again
    };

    task automatic check(input bit ok, input string what, input int req,
                         input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic finish_sim();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_sim();
        end
    end

    initial begin
        int mc, wc;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 outputs held low in reset
        check(monitor_on == 1'b0, "monitor_on in reset", 1, monitor_on, 0);
        check(wake_req == 1'b0, "wake_req in reset", 1, wake_req, 0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            sleep_mode = VEC[i].sl;
            lo = VEC[i].lo;
            dm = VEC[i].dm;
            hi = VEC[i].hi;
            mc = 0;
            wc = 0;
            for (int c = 0; c < int'(VEC[i].hold); c++) begin
                @(posedge clk);
                @(negedge clk);
                if (monitor_on) mc++;
                if (wake_req) wc++;
                if (monitor_on && wake_req) overlaps++;
            end
            check(monitor_on == VEC[i].mon, $sformatf("vec %0d monitor_on at end", i),
                  int'(VEC[i].req), monitor_on, VEC[i].mon);
            check(wc == int'(VEC[i].wk), $sformatf("vec %0d wake pulses", i),
                  int'(VEC[i].req), wc, VEC[i].wk);
            check(mc == int'(VEC[i].mcnt), $sformatf("vec %0d monitor cycles", i),
                  int'(VEC[i].req), mc, VEC[i].mcnt);
        end

        // R10 wake never coincides with monitoring
        check(overlaps == 0, "wake and monitor overlap count", 10, overlaps, 0);

        // R1 reset while monitoring clears outputs at the next edge
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(monitor_on == 1'b0, "monitor_on after mid-run reset", 1, monitor_on, 0);
        check(wake_req == 1'b0, "wake_req after mid-run reset", 1, wake_req, 0);

        // R2 latency after reset release with bus already low
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check(monitor_on == 1'b0, "monitor_on one edge after release", 2, monitor_on, 0);
        @(posedge clk); @(negedge clk);
        check(monitor_on == 1'b0, "monitor_on two edges after release", 2, monitor_on, 0);
        @(posedge clk); @(negedge clk);
        check(monitor_on == 1'b1, "monitor_on three edges after release", 2, monitor_on, 1);

        done = 1'b1;
        finish_sim();
    end
endmodule